// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

The block arbitrates among 28 level-sensitive interrupt request lines. Each request is first gated by a per-source enable bit. The surviving requests then compete on a programmable 3-bit level. Level 0 is the most urgent. When levels are equal, the lower source number wins.

The winning source number is combined with a 16-bit base value into a word-aligned pointer. That pointer selects an entry in a 32-entry table of service-routine addresses held in memory. The block also drives a summary interrupt line toward the processor.

Software reaches the block through a simple synchronous register bus. The bus carries a word address, a write strobe, 32-bit write data and registered 32-bit read data. It gives access to the base register, the read-only vector word, the enable mask, a nesting-control bit and four packed level registers.

Top module: `vic_prio_ctrl`

## Requirements
- R1: After reset, every register reads 0, `vec_addr_o` is 0 and `irq_o` is low.
- R2: The base register at word address 0 stores write-data bits 15:0. Its bits 31:16 always read 0 and writes to them have no effect.
- R3: The vector word keeps bits 31:23 and 1:0 at 0, holds the base in bits 22:7 and the source number in bits 6:2. It is driven on `vec_addr_o` and can be read at word address 1. Writes to address 1 are ignored.
- R4: The level of source k (1 to 27) sits in the register at word address 4 + k/8, bits 4*(k%8)+2 down to 4*(k%8). The top bit of each 4-bit slot reads 0. The slot of source 0 and the slots above source 27 read 0.
- R5: The enable mask at word address 2 holds one bit per source in bits 27:0, and bits 31:28 read 0. A source whose bit is 0 takes no part in arbitration and does not raise `irq_o`.
- R6: Among enabled active sources, the one with the lowest level number wins.
- R7: When several enabled active sources share the lowest level, the lowest source number wins.
- R8: Source 0 has a fixed level of 0, so when it is enabled and active it always wins.
- R9: The nesting-control bit is bit 0 at word address 3, and its other bits read 0. While that bit is 0, the source field of the vector word reads 0 and the base field is still shown.
- R10: `irq_o` is high exactly when at least one enabled source was requesting at the previous clock edge.
- R11: The vector word reflects the requests, mask, levels and base sampled at the previous clock edge. Bus read data appears one clock after the address is presented.
- R12: When no enabled source is requesting, the source field of the vector word is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | 28 | Level interrupt requests, one per source |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Any enabled request active |
| vec_addr_o | output | 32 | Registered vector word (pointer into the routine table) |

## Verification
The assertions check every cycle that the reserved bits of the vector word stay zero and that the base field tracks the stored base. They also check that `irq_o` follows the masked requests, that a non-zero source field names a source that was enabled and requesting, and that the field is zero whenever nesting was off. Whether the winner is the correct one under level ordering, tie-breaking and the fixed level of source 0 is shown only by the bench's scenarios against its own model. The same holds for the packed field layout, the masking of reserved bits on writes and the read-back of each register.

// File: rtl/vic_pkg.sv
// Shared constants of the vectored interrupt priority controller.
// Assumes the base field, source field and two alignment zeros fit into
// one data word.
package vic_pkg;
    localparam int VIC_NUM_SRC      = 28;
    localparam int VIC_LVL_W        = 3;
    localparam int VIC_IDX_W        = 5;
    localparam int VIC_BASE_W       = 16;
    localparam int VIC_DATA_W       = 32;
    localparam int VIC_ADDR_W       = 4;
    localparam int VIC_FIELD_STRIDE = 4;
    localparam int VIC_ALIGN_W      = 2;

    // Register word addresses.
    localparam int ADR_BASE  = 0;
    localparam int ADR_VEC   = 1;
    localparam int ADR_EN    = 2;
    localparam int ADR_NEST  = 3;
    localparam int ADR_PRIO0 = 4;
endpackage

// File: rtl/vic_prio_regs.sv
// Register file: vector base, enable mask, nesting-control bit and packed
// per-source levels, plus a registered read multiplexer.
// Assumes one write per cycle. Source 0 has no storage and reports level 0.
// Reserved bits have no storage and read as zero.
module vic_prio_regs
    import vic_pkg::*;
#(
    parameter int NUM_SRC      = VIC_NUM_SRC,
    parameter int LVL_W        = VIC_LVL_W,
    parameter int BASE_W       = VIC_BASE_W,
    parameter int DATA_W       = VIC_DATA_W,
    parameter int ADDR_W       = VIC_ADDR_W,
    parameter int FIELD_STRIDE = VIC_FIELD_STRIDE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     we_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [DATA_W-1:0]        vec_i,
    output logic [BASE_W-1:0]        base_o,
    output logic [NUM_SRC-1:0]       en_o,
    output logic                     nest_o,
    output logic [NUM_SRC*LVL_W-1:0] prio_o,
    output logic [DATA_W-1:0]        rdata_o
);
    localparam int FPR = DATA_W / FIELD_STRIDE;

    logic [DATA_W-1:0] rd_d;

    // Store the base, enable mask and nesting bit on addressed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            en_o   <= '0;
            nest_o <= 1'b0;
        end else if (we_i) begin
            if (addr_i == ADDR_W'(ADR_BASE)) base_o <= wdata_i[BASE_W-1:0];
            if (addr_i == ADDR_W'(ADR_EN))   en_o   <= wdata_i[NUM_SRC-1:0];
            if (addr_i == ADDR_W'(ADR_NEST)) nest_o <= wdata_i[0];
        end
    end

    // One level register per prioritizable source; source 0 is fixed at 0.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_lvl
        if (k == 0) begin : g_fixed
            assign prio_o[0 +: LVL_W] = '0;
        end else begin : g_prog
            logic [LVL_W-1:0] lvl_q;
            // Capture this source's slot when its packed register is written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q <= '0;
                end else if (we_i && addr_i == ADDR_W'(ADR_PRIO0 + k / FPR)) begin
                    lvl_q <= wdata_i[(k % FPR) * FIELD_STRIDE +: LVL_W];
                end
            end
            assign prio_o[k*LVL_W +: LVL_W] = lvl_q;
        end
    end

    // Select the read word for the presented address.
    always_comb begin
        rd_d = '0;
        if (addr_i == ADDR_W'(ADR_BASE)) begin
            rd_d[BASE_W-1:0] = base_o;
        end else if (addr_i == ADDR_W'(ADR_VEC)) begin
            rd_d = vec_i;
        end else if (addr_i == ADDR_W'(ADR_EN)) begin
            rd_d[NUM_SRC-1:0] = en_o;
        end else if (addr_i == ADDR_W'(ADR_NEST)) begin
            rd_d[0] = nest_o;
        end else begin
            for (int k = 1; k < NUM_SRC; k++) begin
                if (addr_i == ADDR_W'(ADR_PRIO0 + k / FPR)) begin
                    rd_d[(k % FPR) * FIELD_STRIDE +: LVL_W] = prio_o[k*LVL_W +: LVL_W];
                end
            end
        end
    end

    // Register the read data so it is stable for a whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= rd_d;
    end
endmodule

// File: rtl/vic_arbiter.sv
// Combinational priority arbiter: picks the requesting source with the
// lowest level number and breaks ties toward the lowest source number.
// Assumes the requests arrive already masked.
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NUM_SRC = VIC_NUM_SRC,
    parameter int LVL_W   = VIC_LVL_W,
    parameter int IDX_W   = VIC_IDX_W
) (
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC*LVL_W-1:0] prio_i,
    output logic                     any_o,
    output logic [IDX_W-1:0]         win_o
);
    logic [LVL_W-1:0] best;

    // Scan upward; only a strictly lower level replaces the current pick.
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        best  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!any_o || prio_i[i*LVL_W +: LVL_W] < best)) begin
                any_o = 1'b1;
                best  = prio_i[i*LVL_W +: LVL_W];
                win_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_prio_ctrl.sv
// Top of the vectored interrupt priority controller. Masks the requests,
// arbitrates them and registers the vector word and the summary IRQ.
// Assumes the pointer table is word aligned at base << (IDX_W + ALIGN_W).
module vic_prio_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC = VIC_NUM_SRC,
    parameter int LVL_W   = VIC_LVL_W,
    parameter int IDX_W   = VIC_IDX_W,
    parameter int BASE_W  = VIC_BASE_W,
    parameter int DATA_W  = VIC_DATA_W,
    parameter int ADDR_W  = VIC_ADDR_W,
    parameter int ALIGN_W = VIC_ALIGN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_we_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic [DATA_W-1:0]  vec_addr_o
);
    localparam int VEC_USED = BASE_W + IDX_W + ALIGN_W;

    logic [BASE_W-1:0]        base_q;
    logic [NUM_SRC-1:0]       en_q;
    logic                     nest_q;
    logic [NUM_SRC*LVL_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]       req_masked;
    logic                     any_req;
    logic [IDX_W-1:0]         win_idx;
    logic [IDX_W-1:0]         idx_sel;
    logic [DATA_W-1:0]        vec_d;

    vic_prio_regs #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .BASE_W(BASE_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_STRIDE(VIC_FIELD_STRIDE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .we_i(bus_we_i),
        .wdata_i(bus_wdata_i), .vec_i(vec_addr_o), .base_o(base_q),
        .en_o(en_q), .nest_o(nest_q), .prio_o(prio_flat), .rdata_o(bus_rdata_o)
    );

    assign req_masked = irq_src_i & en_q;

    vic_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .req_i(req_masked), .prio_i(prio_flat), .any_o(any_req), .win_o(win_idx)
    );

    // Splice base and (nesting-gated) winner into a word-aligned pointer.
    always_comb begin
        idx_sel = nest_q ? win_idx : '0;
        vec_d   = '0;
        vec_d[VEC_USED-1:0] = {base_q, idx_sel, {ALIGN_W{1'b0}}};
    end

    // Register the vector word and the summary interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_addr_o <= '0;
            irq_o      <= 1'b0;
        end else begin
            vec_addr_o <= vec_d;
            irq_o      <= any_req;
        end
    end
endmodule

// File: rtl/vic_prio_ctrl_chk.sv
// Checker for vic_prio_ctrl: watches the vector word and the summary IRQ
// against the masked requests and register state of the previous cycle.
module vic_prio_ctrl_chk
    import vic_pkg::*;
#(
    parameter int NUM_SRC = VIC_NUM_SRC,
    parameter int IDX_W   = VIC_IDX_W,
    parameter int BASE_W  = VIC_BASE_W,
    parameter int DATA_W  = VIC_DATA_W,
    parameter int ALIGN_W = VIC_ALIGN_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_src_i,
    input logic [NUM_SRC-1:0] en_q,
    input logic [BASE_W-1:0]  base_q,
    input logic               nest_q,
    input logic               irq_o,
    input logic [DATA_W-1:0]  vec_addr_o
);
    localparam int IDX_LSB  = ALIGN_W;
    localparam int BASE_LSB = ALIGN_W + IDX_W;
    localparam int TOP_LSB  = BASE_LSB + BASE_W;

    logic [(1<<IDX_W)-1:0] req_d;
    logic [IDX_W-1:0]      idx;

    // Keep last cycle's masked requests, padded to the full index range.
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= '0;
        else        req_d <= (1<<IDX_W)'(irq_src_i & en_q);
    end

    assign idx = vec_addr_o[IDX_LSB +: IDX_W];

    AST_VEC_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_addr_o[ALIGN_W-1:0] == '0) && (vec_addr_o[DATA_W-1:TOP_LSB] == '0)); // R3
    AST_VEC_BASE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr_o[BASE_LSB +: BASE_W] == $past(base_q)); // R3
    AST_IRQ_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (req_d != '0)); // R10
    AST_WINNER_REQUESTING: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0) |-> req_d[idx]); // R12
    AST_NO_NEST_NO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(nest_q) |-> (idx == '0)); // R9
endmodule

bind vic_prio_ctrl vic_prio_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i), .en_q(en_q),
    .base_q(base_q), .nest_q(nest_q), .irq_o(irq_o), .vec_addr_o(vec_addr_o)
);

// File: tb/vic_prio_ctrl_bench.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them against the outputs at sample points away from clock edges.
module vic_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] irq_src = '0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [31:0] vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 bus read, 1 vector port, 2 irq port
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  sample_ev;

    // Bench-side model of the register state.
    logic [15:0] base_m = '0;
    logic [27:0] en_m = '0;
    logic        nest_m = 1'b0;
    logic [27:0] src_m = '0;
    logic [2:0]  prio_m [28];

    always #4 clk = ~clk;

    vic_prio_ctrl u_vic_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .vec_addr_o(vec)
    );

    // Monitor: pop one expected item per sample event and compare.
    always @(sample_ev) begin
        item_t       it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = (it.kind == 0) ? rdata : (it.kind == 1) ? vec : {31'b0, irq};
        n_chk++;
        if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
    end

    task automatic push_chk(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; we = 1'b1; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); addr = a; we = 1'b0;
        @(posedge clk); #1;
        push_chk(0, exp, tag);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] prio_word(input int r);
        logic [31:0] w = '0;
        for (int j = 0; j < 8; j++) begin
            int s = r * 8 + j;
            if (s >= 1 && s < 28) w[4*j +: 3] = prio_m[s];
        end
        return w;
    endfunction

    task automatic write_prios();
        for (int r = 0; r < 4; r++) bus_wr(4'(4 + r), prio_word(r));
    endtask

    function automatic logic [31:0] exp_vec();
        logic [27:0] req = src_m & en_m;
        logic [4:0]  win = '0;
        logic [2:0]  best = '0;
        bit          found = 1'b0;
        for (int i = 0; i < 28; i++) begin
            logic [2:0] l = (i == 0) ? 3'd0 : prio_m[i];
            if (req[i] && (!found || l < best)) begin
                found = 1'b1; best = l; win = 5'(i);
            end
        end
        if (!nest_m) win = '0;
        return {9'b0, base_m, win, 2'b00};
    endfunction

    task automatic apply_src(input logic [27:0] v);
        @(negedge clk); irq_src = v; src_m = v;
        settle();
    endtask

    task automatic chk_outputs(input string tag);
        push_chk(1, exp_vec(), tag);
        push_chk(2, {31'b0, |(src_m & en_m)}, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 28; i++) prio_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        settle();

        // R1: reset state.
        for (int a = 0; a < 8; a++) bus_rd(4'(a), 32'h0, "R1 reset register");
        push_chk(1, 32'h0, "R1 reset vector");
        push_chk(2, 32'h0, "R1 reset irq");

        // R2: base keeps 16 bits, upper bits read zero.
        bus_wr(4'd0, 32'hABCD_1234); base_m = 16'h1234;
        bus_rd(4'd0, 32'h0000_1234, "R2 base readback");

        // R5 / R9: mask and nest-control reserved bits.
        bus_wr(4'd2, 32'hFFFF_FFFF); en_m = '1;
        bus_rd(4'd2, 32'h0FFF_FFFF, "R5 enable readback");
        bus_wr(4'd3, 32'hFFFF_FFFF); nest_m = 1'b1;
        bus_rd(4'd3, 32'h0000_0001, "R9 nest readback");

        // R4: packed levels, reserved slot bits read zero.
        for (int r = 0; r < 4; r++) bus_wr(4'(4 + r), 32'hFFFF_FFFF);
        for (int i = 1; i < 28; i++) prio_m[i] = 3'd7;
        bus_rd(4'd4, 32'h7777_7770, "R4 level reg 0");
        bus_rd(4'd5, 32'h7777_7777, "R4 level reg 1");
        bus_rd(4'd7, 32'h0000_7777, "R4 level reg 3");

        // R3: write to vector address is ignored; vector reads back base.
        bus_wr(4'd1, 32'hFFFF_FFFF);
        settle();
        bus_rd(4'd1, {9'b0, 16'h1234, 7'b0}, "R3 vector write ignored R12");

        // R6: lower level wins (source 3 -> field 00011).
        prio_m[3] = 3'd2; prio_m[10] = 3'd5; write_prios();
        apply_src(28'h0000_408);
        chk_outputs("R6 lower level wins");
        bus_rd(4'd1, {9'b0, 16'h1234, 5'd3, 2'b00}, "R3 R11 vector via bus");

        // R7: tie goes to the lower source number.
        prio_m[12] = 3'd1; prio_m[20] = 3'd1; write_prios();
        apply_src(28'h010_1000);
        chk_outputs("R7 tie lowest index");

        // R8: source 0 beats a level-0 source.
        prio_m[5] = 3'd0; write_prios();
        apply_src(28'h000_0021);
        chk_outputs("R8 source 0 wins");

        // R5: masked source ignored.
        bus_wr(4'd2, 32'h0FFF_FFF7); en_m = 28'hFFF_FFF7;
        apply_src(28'h0000_408);
        chk_outputs("R5 masked source ignored");
        bus_wr(4'd2, 32'h0000_0008); en_m = 28'h000_0008;
        apply_src(28'h000_0400);
        chk_outputs("R5 R10 only masked source active");
        bus_wr(4'd2, 32'h0FFF_FFFF); en_m = '1;

        // R9: nesting off hides the source field.
        bus_wr(4'd3, 32'h0); nest_m = 1'b0;
        apply_src(28'h0000_408);
        chk_outputs("R9 nesting off");
        bus_wr(4'd3, 32'h1); nest_m = 1'b1;

        // R11: one-cycle latency of the vector word.
        @(negedge clk); irq_src = 28'h000_0400; src_m = 28'h000_0400;
        push_chk(1, {9'b0, 16'h1234, 5'd3, 2'b00}, "R11 old vector before edge");
        @(posedge clk); #1;
        chk_outputs("R11 new vector after edge");

        // R12 / R10: nothing requesting.
        apply_src(28'h0);
        chk_outputs("R12 no request");

        // R6 R7: mixed patterns against the model.
        for (int n = 0; n < 30; n++) begin
            for (int i = 1; i < 28; i++) prio_m[i] = 3'($urandom_range(0, 7));
            write_prios();
            apply_src(28'($urandom & $urandom));
            chk_outputs("R6 R7 mixed pattern");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule